// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sorts every memory access that falls in the legacy window between 640 KB and 1 MB into one of nineteen programmable regions. It returns that region's access attributes: read allowed, write allowed, cacheable, routed to PCI, and claimed by the graphics pipeline. Three regions of unequal size cover the video area from A0000h to BFFFFh. Sixteen equal 16 KB regions cover the option-ROM area from C0000h to FFFFFh.

Before the window is decoded, the block can clear address bit 20 so that addresses wrap at 1 MB. Cycles marked as SMI are exempt from this wrap. An address outside the window receives fixed default attributes, which depend on whether it lies below or above a programmable top-of-memory bound. If the region's bits forbid the access, a deny flag is raised so that the surrounding logic redirects the access rather than completing it to memory. Control state is loaded through a simple write port. Each access result appears on registered outputs one clock after the request.

Top module: `lmr_decoder`

## Requirements
- R1: After a synchronous reset, `out_valid` is low, every region's attribute bits are zero, A20 wrapping is off and the top-of-memory bound is zero. A legacy-window access made in this state is therefore denied and has no attributes set.
- R2: A request accepted in one cycle produces `out_valid` high, with its results, in the next cycle. A cycle with no request produces `out_valid` low in the next cycle.
- R3: The region index is fixed. Index 0 is A0000h–AFFFFh, index 1 is B0000h–B7FFFh and index 2 is B8000h–BFFFFh. Index 3+k covers C0000h+k·4000h up to 16 KB above that, for k from 0 to 15. Any address outside A0000h–FFFFFh reports index 31 with `out_legacy` low.
- R4: Writing `cfg_sel` values 0 to 18 loads that region's attributes from `cfg_wdata`. Bit 0 is read, bit 1 is write, bit 2 is cacheable, bit 3 is PCI and bit 4 is graphics. A legacy access returns these bits on `out_rd_en`, `out_wr_en`, `out_cache`, `out_pci` and `out_gfx`.
- R5: Only regions 0 to 2 can hold the graphics bit. For regions 3 to 18, bit 4 of the write data is discarded and `out_gfx` stays low.
- R6: A legacy access raises `out_deny` when it is a write and the region's write bit is clear. It also raises `out_deny` when it is a read and the region's read bit is clear. A non-legacy access never raises `out_deny`.
- R7: Writing `cfg_sel` 19 sets A20 wrapping from `cfg_wdata` bit 0. While wrapping is on, a non-SMI access has bit 20 of `out_addr` cleared. An SMI access (`acc_smi` high) is passed through unchanged.
- R8: The wrap is applied before region decode and before the top-of-memory compare, so 1A0000h with wrapping on decodes as region 0.
- R9: Writing `cfg_sel` 20 loads the full `cfg_wdata` as the top-of-memory bound. A non-legacy address below that bound returns read, write and cacheable set, with PCI and graphics clear.
- R10: A non-legacy address at or above the top-of-memory bound returns read, write and PCI set, with cacheable and graphics clear.
- R11: A control write and an access in the same cycle: the access uses the control state from before the write. The write takes effect from the next access onward.
- R12: A write with a `cfg_sel` value from 21 to 31 changes no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 5 | Control target: 0–18 region, 19 wrap control, 20 top of memory |
| cfg_wdata | input | ADDR_W | Control write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_smi | input | 1 | Access is an SMI cycle (exempt from wrap) |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_addr | output | ADDR_W | Address after optional bit-20 clear |
| out_rd_en | output | 1 | Read permitted |
| out_wr_en | output | 1 | Write permitted |
| out_cache | output | 1 | Cacheable |
| out_pci | output | 1 | Route to PCI |
| out_gfx | output | 1 | Graphics pipeline claims the access |
| out_deny | output | 1 | Access forbidden by region bits; redirect |
| out_legacy | output | 1 | Address fell in the legacy window |
| out_region | output | 5 | Region index, 31 when outside the window |

## Verification
Two things can happen in the same clock: a control write and an access whose result depends on the register being written. This applies to a region's attributes, the wrap enable and the top-of-memory bound. The bench provokes this on purpose by writing region 0 and accessing region 0 in one cycle, and by doing the same with the wrap control. The random phase also mixes writes with accesses in the same cycles. Its reference model computes each expected result from its state before applying the cycle's write, so any design that lets the new value pass through to the same-cycle access is reported.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  // Region map sizing: three video-area regions plus ROM segments
  localparam int NUM_VGA       = 3;
  localparam int SEG_LSB       = 14;                  // 16 KB ROM segments
  localparam int WIN_MSB       = 19;                  // window lies below 1 MB
  localparam int ROM_SEG_BITS  = 18 - SEG_LSB;        // C0000h..FFFFFh span 256 KB
  localparam int NUM_ROM       = 1 << ROM_SEG_BITS;
  localparam int NUM_REGIONS   = NUM_VGA + NUM_ROM;

  localparam int SEL_W = 5;
  localparam int IDX_W = 5;

  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_REGIONS);
  localparam logic [SEL_W-1:0] SEL_TOP  = SEL_W'(NUM_REGIONS + 1);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  typedef struct packed {
    logic gfx;
    logic pci;
    logic cache;
    logic wr;
    logic rd;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  localparam attr_t ATTR_LOW_DRAM = '{gfx: 1'b0, pci: 1'b0, cache: 1'b1, wr: 1'b1, rd: 1'b1};
  localparam attr_t ATTR_HIGH_BUS = '{gfx: 1'b0, pci: 1'b1, cache: 1'b0, wr: 1'b1, rd: 1'b1};

endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wdata,
  output attr_t             attr_tbl [NUM_REGIONS],
  output logic              a20_en,
  output logic [ADDR_W-1:0] tom
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    attr_t held;
    attr_t incoming;

    always_comb begin
      incoming = attr_t'(wdata[ATTR_W-1:0]);
      if (g >= NUM_VGA) incoming.gfx = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)                            held <= '0;
      else if (we && sel == SEL_W'(g))    held <= incoming;
    end

    assign attr_tbl[g] = held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a20_en <= 1'b0;
      tom    <= '0;
    end else if (we) begin
      if (sel == SEL_CTRL) a20_en <= wdata[0];
      if (sel == SEL_TOP)  tom    <= wdata;
    end
  end

endmodule

// File: rtl/lmr_a20_mask.sv
module lmr_a20_mask #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              en,
  input  logic              smi,
  output logic [ADDR_W-1:0] addr_out
);

  always_comb begin
    addr_out = addr_in;
    if (en && !smi) addr_out[20] = 1'b0;
  end

endmodule

// File: rtl/lmr_region_decode.sv
module lmr_region_decode
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:SEG_LSB] addr_hi,
  output logic                    legacy,
  output logic [IDX_W-1:0]        idx
);

  logic                   above_1m;
  logic [WIN_MSB:SEG_LSB] w;

  assign above_1m = |addr_hi[ADDR_W-1:WIN_MSB+1];
  assign w        = addr_hi[WIN_MSB:SEG_LSB];

  always_comb begin
    legacy = 1'b0;
    idx    = IDX_NONE;
    if (!above_1m) begin
      if (w[19:18] == 2'b11) begin
        // option-ROM area: equal 16 KB segments
        legacy = 1'b1;
        idx    = IDX_W'(NUM_VGA) + IDX_W'(w[17:SEG_LSB]);
      end else if (w[19:17] == 3'b101) begin
        // video area: one 64 KB and two 32 KB regions
        legacy = 1'b1;
        if (!w[16])      idx = IDX_W'(0);
        else if (!w[15]) idx = IDX_W'(1);
        else             idx = IDX_W'(2);
      end
    end
  end

endmodule

// File: rtl/lmr_decoder.sv
module lmr_decoder
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_smi,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_rd_en,
  output logic              out_wr_en,
  output logic              out_cache,
  output logic              out_pci,
  output logic              out_gfx,
  output logic              out_deny,
  output logic              out_legacy,
  output logic [4:0]        out_region
);

  attr_t             attr_tbl [NUM_REGIONS];
  logic              a20_en;
  logic [ADDR_W-1:0] tom;
  logic [ADDR_W-1:0] eff_addr;
  logic              dec_legacy;
  logic [IDX_W-1:0]  dec_idx;
  attr_t             nxt_attr;
  logic              nxt_deny;

  lmr_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .attr_tbl (attr_tbl),
    .a20_en   (a20_en),
    .tom      (tom)
  );

  lmr_a20_mask #(.ADDR_W(ADDR_W)) u_mask (
    .addr_in  (acc_addr),
    .en       (a20_en),
    .smi      (acc_smi),
    .addr_out (eff_addr)
  );

  lmr_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_hi (eff_addr[ADDR_W-1:SEG_LSB]),
    .legacy  (dec_legacy),
    .idx     (dec_idx)
  );

  always_comb begin
    nxt_deny = 1'b0;
    if (dec_legacy && dec_idx < IDX_W'(NUM_REGIONS)) begin
      nxt_attr = attr_tbl[dec_idx];
      nxt_deny = acc_write ? !nxt_attr.wr : !nxt_attr.rd;
    end else if (eff_addr < tom) begin
      nxt_attr = ATTR_LOW_DRAM;
    end else begin
      nxt_attr = ATTR_HIGH_BUS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_rd_en  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_cache  <= 1'b0;
      out_pci    <= 1'b0;
      out_gfx    <= 1'b0;
      out_deny   <= 1'b0;
      out_legacy <= 1'b0;
      out_region <= IDX_NONE;
    end else begin
      out_valid  <= acc_valid;
      out_addr   <= eff_addr;
      out_rd_en  <= nxt_attr.rd;
      out_wr_en  <= nxt_attr.wr;
      out_cache  <= nxt_attr.cache;
      out_pci    <= nxt_attr.pci;
      out_gfx    <= nxt_attr.gfx;
      out_deny   <= nxt_deny;
      out_legacy <= dec_legacy;
      out_region <= dec_idx;
    end
  end

endmodule

// File: rtl/lmr_decoder_chk.sv
module lmr_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_smi,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_rd_en,
  input logic              out_wr_en,
  input logic              out_cache,
  input logic              out_pci,
  input logic              out_gfx,
  input logic              out_deny,
  input logic              out_legacy,
  input logic [4:0]        out_region
);

  // R2: result valid tracks the request one cycle later
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> out_valid == $past(acc_valid));

  // R3: legacy results carry an in-range index and an address below 1 MB
  a_r3_legacy_index: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legacy) |-> (out_region <= 5'd18 && out_addr[ADDR_W-1:20] == '0));

  // R3: non-legacy results carry the "none" index
  a_r3_none_index: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_legacy) |-> out_region == 5'd31);

  // R5: graphics claim only from the three video regions
  a_r5_gfx_video_only: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_gfx) |-> (out_legacy && out_region <= 5'd2));

  // R6: denial implies a missing permission and only inside the window
  a_r6_deny_cause: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_deny) |-> (out_legacy && !(out_rd_en && out_wr_en)));

  // R7: SMI cycles keep their address untouched
  a_r7_smi_bypass: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_smi) |=> out_addr == $past(acc_addr));

  // R9 and R10: defaults outside the window are exactly one of two sets
  a_r9_r10_defaults: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_legacy) |-> (out_rd_en && out_wr_en && !out_gfx && (out_cache != out_pci)));

endmodule

bind lmr_decoder lmr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_smi    (acc_smi),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_rd_en  (out_rd_en),
  .out_wr_en  (out_wr_en),
  .out_cache  (out_cache),
  .out_pci    (out_pci),
  .out_gfx    (out_gfx),
  .out_deny   (out_deny),
  .out_legacy (out_legacy),
  .out_region (out_region)
);

// File: tb/tb_lmr_decoder.sv
module tb_lmr_decoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [4:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        acc_smi;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_rd_en, out_wr_en, out_cache, out_pci, out_gfx, out_deny, out_legacy;
  logic [4:0]  out_region;

  always #2 clk = ~clk;   // 250 MHz

  lmr_decoder #(.ADDR_W(32)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_smi(acc_smi),
    .out_valid(out_valid), .out_addr(out_addr), .out_rd_en(out_rd_en), .out_wr_en(out_wr_en),
    .out_cache(out_cache), .out_pci(out_pci), .out_gfx(out_gfx), .out_deny(out_deny),
    .out_legacy(out_legacy), .out_region(out_region)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [4:0]  m_attr [19];
  bit          m_wrap;
  logic [31:0] m_top;

  // expected result of the current cycle
  bit          e_valid;
  logic [40:0] e_vec;

  function automatic int region_of(input logic [31:0] a);
    if (a < 32'hA0000 || a >= 32'h100000) return -1;
    if (a < 32'hB0000) return 0;
    if (a < 32'hB8000) return 1;
    if (a < 32'hC0000) return 2;
    return 3 + int'((a - 32'hC0000) / 32'h4000);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 19; i++) m_attr[i] = '0;
    m_wrap = 0;
    m_top  = '0;
  endtask

  task automatic predict(input bit v, input logic [31:0] a, input bit w, input bit s);
    logic [31:0] ma;
    logic [4:0]  at;
    bit rd, wr, ca, pc, gx, dn, lg;
    int r;
    ma = a;
    if (m_wrap && !s) ma[20] = 1'b0;
    r = region_of(ma);
    dn = 0;
    if (r >= 0) begin
      at = m_attr[r];
      rd = at[0]; wr = at[1]; ca = at[2]; pc = at[3]; gx = at[4];
      dn = w ? !wr : !rd;
      lg = 1;
    end else begin
      lg = 0; gx = 0; rd = 1; wr = 1;
      if (ma < m_top) begin ca = 1; pc = 0; end
      else            begin ca = 0; pc = 1; end
    end
    e_valid = v;
    e_vec = {ma, rd, wr, ca, pc, gx, dn, lg, (r >= 0) ? 5'(r) : 5'd31};
    e_vec = {e_vec[40:5], e_vec[4:0]};
  endtask

  task automatic model_write(input bit we, input logic [4:0] sel, input logic [31:0] wd);
    if (!we) return;
    if (sel < 5'd19) m_attr[sel] = (sel < 5'd3) ? wd[4:0] : {1'b0, wd[3:0]};
    else if (sel == 5'd19) m_wrap = wd[0];
    else if (sel == 5'd20) m_top = wd;
  endtask

  task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare after the next posedge
  task automatic cyc(input bit we, input logic [4:0] sel, input logic [31:0] wd,
                     input bit v, input logic [31:0] a, input bit w, input bit s,
                     input string req);
    logic [40:0] act;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_write = w; acc_smi = s;
    predict(v, a, w, s);
    model_write(we, sel, wd);
    @(posedge clk);
    @(negedge clk);
    act = {out_addr, out_rd_en, out_wr_en, out_cache, out_pci, out_gfx, out_deny, out_legacy, out_region};
    check(out_valid == e_valid, "R2", 64'(out_valid), 64'(e_valid));
    if (e_valid) check(act == e_vec, req, 64'(act), 64'(e_vec));
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] wd, input string req);
    cyc(1, sel, wd, 0, 32'h0, 0, 0, req);
  endtask

  task automatic rd(input logic [31:0] a, input string req);
    cyc(0, 5'd0, 32'h0, 1, a, 0, 0, req);
  endtask

  task automatic wa(input logic [31:0] a, input string req);
    cyc(0, 5'd0, 32'h0, 1, a, 1, 0, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    acc_valid = 0; acc_addr = '0; acc_write = 0; acc_smi = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);

    // R1: reset state denies legacy accesses; zero top places all else above bound
    rd(32'h000A0000, "R1");
    wa(32'h000C4000, "R1");
    rd(32'h00050000, "R10");

    // R9/R10: top-of-memory bound
    wr(5'd20, 32'h01000000, "R9");
    rd(32'h00050000, "R9");
    rd(32'h00FFFFFF, "R9");
    rd(32'h01000000, "R10");
    wa(32'h80000000, "R10");

    // R4/R5: distinct pattern per region, bit 4 always offered
    for (int k = 0; k < 19; k++) wr(5'(k), 32'h10 | 32'((k * 7 + 3) & 15), "R4");
    // R3 boundaries
    rd(32'h0009FFFF, "R3");
    rd(32'h000A0000, "R3");
    rd(32'h000AFFFF, "R3");
    rd(32'h000B0000, "R3");
    rd(32'h000B7FFF, "R3");
    rd(32'h000B8000, "R3");
    rd(32'h000BFFFF, "R3");
    rd(32'h000C0000, "R3");
    rd(32'h000FFFFF, "R3");
    rd(32'h00100000, "R3");
    // every region, read and write, first and last byte: R4 R5 R6
    for (int k = 0; k < 16; k++) begin
      rd(32'hC0000 + 32'(k) * 32'h4000, "R5");
      wa(32'hC3FFF + 32'(k) * 32'h4000, "R6");
    end
    wa(32'h000A1234, "R6");
    wa(32'h000B2222, "R6");
    rd(32'h000B9999, "R4");

    // R7/R8: bit-20 wrap
    wr(5'd19, 32'h1, "R7");
    rd(32'h001A0000, "R8");
    rd(32'h00100000, "R7");
    cyc(0, 5'd0, 32'h0, 1, 32'h001A0000, 0, 1, "R7");
    cyc(0, 5'd0, 32'h0, 1, 32'h001C8000, 1, 1, "R7");
    wa(32'h001FFFFF, "R8");

    // R11: write and access in the same cycle
    cyc(1, 5'd0, 32'h1F, 1, 32'h000A0000, 1, 0, "R11");
    rd(32'h000A0000, "R11");
    cyc(1, 5'd19, 32'h0, 1, 32'h001A0000, 0, 0, "R11");
    rd(32'h001A0000, "R11");
    cyc(1, 5'd20, 32'h00000000, 1, 32'h00050000, 0, 0, "R11");
    rd(32'h00050000, "R11");

    // R12: unused selects change nothing
    for (int s = 21; s < 32; s++) wr(5'(s), 32'hFFFFFFFF, "R12");
    rd(32'h000A0000, "R12");
    rd(32'h001A0000, "R12");
    rd(32'h00050000, "R12");
    for (int k = 0; k < 16; k++) rd(32'hC0000 + 32'(k) * 32'h4000, "R12");

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      int pick;
      pick = int'($urandom_range(0, 3));
      case (pick)
        0: a = 32'hA0000 + ($urandom % 32'h60000);
        1: a = 32'h100000 | (32'hA0000 + ($urandom % 32'h60000));
        2: a = $urandom % 32'h200000;
        default: a = $urandom;
      endcase
      cyc(($urandom % 4) == 0, 5'($urandom), $urandom, ($urandom % 5) != 0, a,
          1'($urandom), ($urandom % 6) == 0, "R3");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule